// File: doc/BRIEF.md
# DDR Read Latency and Mode Controller

This block models the device side of a DDR SDRAM read path together with its mode register. Each clock edge registers a command: no-operation, read, or mode register set, with a 12-bit address. A mode register set decodes the upper address bits to choose normal operation or a DLL reset. Reserved encodings are refused. The low seven bits are kept as the active settings, and the read latency is taken from bits 6:4.

After a read is registered, the block drives a four-beat burst at the programmed latency of 2 or 2.5 clocks. The burst moves one beat on each clock edge, and a strobe toggles with the data. Output-enable rises one half-cycle early, which gives the strobe a low preamble, and falls one half-cycle after the last beat. Burst data comes from a pattern source: beat k carries the column address plus k.

The half-cycle positions are formed from a per-read cycle counter combined with the clock phase, so a rising or falling edge launch needs no second clock. Two burst trackers alternate, so a read issued four clocks after another starts before the first burst has drained.

Top module: `ddr_rdpath`

## Requirements
- R1: During and right after reset, dq_oe, dqs and dq are 0, mode_cfg is 7'b010_0010, and lat_half, dll_rst_pend and mode_rsvd are 0.
- R2: A mode set (cmd 2'b10) with addr[11:7]=5'b00000 and a valid latency code loads mode_cfg from addr[6:0] and clears dll_rst_pend and mode_rsvd at the next rising edge.
- R3: A mode set with addr[11:7]=5'b00010 (only bit 8 set) and a valid latency code loads mode_cfg from addr[6:0], sets dll_rst_pend and clears mode_rsvd.
- R4: A mode set with any other addr[11:7] pattern leaves mode_cfg and dll_rst_pend unchanged and sets mode_rsvd.
- R5: The latency code addr[6:4] is valid only as 3'b010 (2 clocks) or 3'b110 (2.5 clocks). A mode set with any other code is refused in the same way as R4.
- R6: With latency 2, a read (cmd 2'b01) registered at rising edge n puts its first beat on dq at rising edge n+2.
- R7: With latency 2.5, the first beat appears at the falling edge that follows rising edge n+2.
- R8: A burst has four consecutive half-cycle beats with values col, col+1, col+2 and col+3 modulo 2^DW, where col = addr[DW-1:0] of the read. The strobe reads 1,0,1,0 across these beats.
- R9: dq_oe is high, with dqs and dq at 0, for one half-cycle before the first beat and for one half-cycle after the last beat. At all other times outside a burst, dq_oe, dqs and dq are 0.
- R10: Two reads registered four clocks apart produce two complete bursts, with dq_oe low between them.
- R11: A no-operation (2'b00) or the unused code 2'b11 leaves mode_cfg, dll_rst_pend and mode_rsvd unchanged, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges carry data |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Command: 00 no-op, 01 read, 10 mode set, 11 no-op |
| addr | input | 12 | Address; mode bits for a mode set, column for a read |
| dq | output | DW | Burst data |
| dqs | output | 1 | Data strobe |
| dq_oe | output | 1 | Output-enable for dq and dqs |
| mode_cfg | output | 7 | Active mode settings |
| lat_half | output | 1 | Current latency is 2.5 clocks |
| dll_rst_pend | output | 1 | A DLL-reset load is waiting for a normal load |
| mode_rsvd | output | 1 | The last mode set was refused |

## Verification
On every cycle, the assertions check the mode register's response to each kind of mode set and to every other command, and that the strobe and data stay quiet while output-enable is low. Only the bench's scenarios can show where the first beat lands for each latency, the order of the beat values, the preamble and postamble widths, and the separation of back-to-back bursts. These need the expected half-cycle timeline of a whole read, which a scoreboard builds for each read the bench issues.

// File: rtl/ddr_rdpath.sv
`timescale 1ns/1ps
module ddr_rdpath #(
  parameter int DW   = 8,
  parameter int BL   = 4,
  parameter int NTRK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd,
  input  logic [11:0]   addr,
  output logic [DW-1:0] dq,
  output logic          dqs,
  output logic          dq_oe,
  output logic [6:0]    mode_cfg,
  output logic          lat_half,
  output logic          dll_rst_pend,
  output logic          mode_rsvd
);
  localparam logic [1:0] CMD_READ = 2'b01;
  localparam logic [1:0] CMD_MRS  = 2'b10;
  localparam int LASTS = 5 + BL;
  localparam int LASTC = LASTS / 2;
  localparam int CW    = $clog2(LASTC + 1);
  localparam int PW    = (NTRK > 1) ? $clog2(NTRK) : 1;
  localparam logic [6:0] CFG_RST = 7'b0100010;

  wire is_rd   = cmd == CMD_READ;
  wire is_mrs  = cmd == CMD_MRS;
  wire lat_ok  = addr[6:4] == 3'b010 || addr[6:4] == 3'b110;
  wire op_norm = addr[11:7] == 5'b00000;
  wire op_dll  = addr[11:7] == 5'b00010;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cfg     <= CFG_RST;
      dll_rst_pend <= 1'b0;
      mode_rsvd    <= 1'b0;
    end else if (is_mrs) begin
      if (lat_ok && (op_norm || op_dll)) begin
        mode_cfg     <= addr[6:0];
        dll_rst_pend <= op_dll;
        mode_rsvd    <= 1'b0;
      end else begin
        mode_rsvd    <= 1'b1;
      end
    end
  end

  assign lat_half = mode_cfg[6:4] == 3'b110;

  logic [PW-1:0] nxt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nxt <= '0;
    else if (is_rd) nxt <= (nxt == PW'(NTRK - 1)) ? '0 : nxt + 1'b1;
  end

  logic [NTRK-1:0] t_oe, t_dqs;
  logic [DW-1:0]   t_dq [NTRK];

  for (genvar g = 0; g < NTRK; g++) begin : g_trk
    logic          act, half, oe_l, dqs_l;
    logic [CW-1:0] cnt;
    logic [DW-1:0] col, dq_l;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act <= 1'b0; half <= 1'b0; cnt <= '0; col <= '0;
      end else if (is_rd && nxt == PW'(g)) begin
        act <= 1'b1; half <= lat_half; cnt <= '0; col <= DW'(addr);
      end else if (act) begin
        if (cnt == CW'(LASTC)) act <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end

    always_comb begin
      int s, first, k;
      s     = int'({cnt, ~clk});
      first = half ? 5 : 4;
      k     = s - first;
      oe_l  = act && s >= first - 1 && s <= first + BL;
      dqs_l = act && k >= 0 && k < BL && k[0] == 1'b0;
      dq_l  = (act && k >= 0 && k < BL) ? col + DW'(k) : '0;
    end

    assign t_oe[g]  = oe_l;
    assign t_dqs[g] = dqs_l;
    assign t_dq[g]  = dq_l;
  end

  always_comb begin
    dq_oe = |t_oe;
    dqs   = |t_dqs;
    dq    = '0;
    for (int i = 0; i < NTRK; i++) dq = dq | t_dq[i];
  end
endmodule

module ddr_rdpath_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cmd,
  input logic [11:0]   addr,
  input logic [DW-1:0] dq,
  input logic          dqs,
  input logic          dq_oe,
  input logic [6:0]    mode_cfg,
  input logic          lat_half,
  input logic          dll_rst_pend,
  input logic          mode_rsvd
);
  wire mrs   = cmd == 2'b10;
  wire latv  = addr[6:4] == 3'b010 || addr[6:4] == 3'b110;
  wire nrm   = mrs && latv && addr[11:7] == 5'b00000;
  wire dllr  = mrs && latv && addr[11:7] == 5'b00010;
  wire bad   = mrs && !nrm && !dllr;

  AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    nrm |=> mode_cfg == $past(addr[6:0]) && !dll_rst_pend && !mode_rsvd); // R2
  AST_DLL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dllr |=> mode_cfg == $past(addr[6:0]) && dll_rst_pend && !mode_rsvd); // R3
  AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> mode_rsvd && $stable(mode_cfg) && $stable(dll_rst_pend)); // R4
  AST_LAT_CODE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs && !latv) |=> mode_rsvd && $stable(mode_cfg)); // R5
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> !dqs && dq == '0); // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs |=> $stable(mode_cfg) && $stable(dll_rst_pend) && $stable(mode_rsvd)); // R11
  AST_LAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm && addr[6:4] == 3'b110) |=> lat_half); // R7
endmodule

bind ddr_rdpath ddr_rdpath_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .dq(dq), .dqs(dqs),
  .dq_oe(dq_oe), .mode_cfg(mode_cfg), .lat_half(lat_half),
  .dll_rst_pend(dll_rst_pend), .mode_rsvd(mode_rsvd));

// File: tb/ddr_rdpath_tb.sv
`timescale 1ns/1ps
module ddr_rdpath_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [11:0] addr = '0;
  logic [7:0] dq;
  logic dqs, dq_oe, lat_half, dll_rst_pend, mode_rsvd;
  logic [6:0] mode_cfg;

  int checks = 0, fails = 0, pe = 0;
  bit mon_on = 1'b0;
  int qh[$];
  logic [8:0] qv[$];
  string qr[$];

  always #2 clk = ~clk;
  always @(posedge clk) pe++;

  ddr_rdpath u_dut (.clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .dq(dq),
    .dqs(dqs), .dq_oe(dq_oe), .mode_cfg(mode_cfg), .lat_half(lat_half),
    .dll_rst_pend(dll_rst_pend), .mode_rsvd(mode_rsvd));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic push(input int h, input logic s, input logic [7:0] d, input string r);
    qh.push_back(h); qv.push_back({s, d}); qr.push_back(r);
  endtask

  // driver: issues a read and queues its expected half-cycle timeline
  task automatic rd(input logic [11:0] a, input bit half, input string tag);
    int n, f;
    @(negedge clk);
    cmd = 2'b01; addr = a;
    n = pe + 1;
    f = half ? 5 : 4;
    push(2*n + f - 1, 1'b0, 8'h00, "R9");
    for (int k = 0; k < 4; k++)
      push(2*n + f + k, (k % 2 == 0), a[7:0] + 8'(k),
           tag != "" ? tag : (k == 0 ? (half ? "R7" : "R6") : "R8"));
    push(2*n + f + 4, 1'b0, 8'h00, "R9");
    @(negedge clk);
    cmd = 2'b00; addr = '0;
  endtask

  task automatic mrs(input logic [1:0] c, input logic [11:0] a);
    @(negedge clk);
    cmd = c; addr = a;
    @(negedge clk);
    cmd = 2'b00; addr = '0;
  endtask

  task automatic sample(input int h);
    if (!mon_on) return;
    if (qh.size() > 0 && qh[0] < h) begin
      fails++; checks++;
      $display("FAIL %s: beat for slot %0d missing, now %0d", qr[0], qh[0], h);
      void'(qh.pop_front()); void'(qv.pop_front()); void'(qr.pop_front());
    end
    if (qh.size() > 0 && qh[0] == h) begin
      chk(qr[0], {dq_oe, dqs, dq}, {1'b1, qv[0]});
      void'(qh.pop_front()); void'(qv.pop_front()); void'(qr.pop_front());
    end else begin
      chk("R9", {dq_oe, dqs, dq}, 10'h000);
    end
  endtask

  // monitor: one sample in each clock phase
  initial forever begin
    @(posedge clk); #1 sample(2*pe);
    @(negedge clk); #1 sample(2*pe + 1);
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {dq_oe, dqs, dq}, 10'h000);
    chk("R1", {mode_cfg, lat_half, dll_rst_pend, mode_rsvd}, {7'b0100010, 3'b000});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {mode_cfg, lat_half, dll_rst_pend, mode_rsvd}, {7'b0100010, 3'b000});
    mon_on = 1'b1;

    rd(12'h0A5, 1'b0, "");                 // R6 R8 R9
    repeat (8) @(negedge clk);

    mrs(2'b10, 12'h162);                    // DLL reset, latency 2.5
    chk("R3", {mode_cfg, lat_half, dll_rst_pend, mode_rsvd}, {7'h62, 3'b110});
    mrs(2'b10, 12'h0A2);                    // bit 7 set: reserved
    chk("R4", {mode_cfg, dll_rst_pend, mode_rsvd}, {7'h62, 2'b11});
    mrs(2'b10, 12'h032);                    // latency code 011
    chk("R5", {mode_cfg, dll_rst_pend, mode_rsvd}, {7'h62, 2'b11});
    mrs(2'b10, 12'h862);                    // bit 11 set
    chk("R4", {mode_cfg, dll_rst_pend, mode_rsvd}, {7'h62, 2'b11});
    mrs(2'b10, 12'h062);                    // normal, latency 2.5
    chk("R2", {mode_cfg, lat_half, dll_rst_pend, mode_rsvd}, {7'h62, 3'b100});

    rd(12'h0F0, 1'b1, "");                 // R7 R8
    repeat (8) @(negedge clk);

    rd(12'h010, 1'b1, "");
    repeat (2) @(negedge clk);
    rd(12'h0FE, 1'b1, "R10");              // wraps to 00, 01
    repeat (8) @(negedge clk);

    mrs(2'b10, 12'h022);                    // normal, latency 2
    chk("R2", {mode_cfg, lat_half, dll_rst_pend, mode_rsvd}, {7'h22, 3'b000});
    mrs(2'b11, 12'h162);
    chk("R11", {mode_cfg, lat_half, dll_rst_pend, mode_rsvd}, {7'h22, 3'b000});
    mrs(2'b00, 12'hFFF);
    chk("R11", {mode_cfg, lat_half, dll_rst_pend, mode_rsvd}, {7'h22, 3'b000});
    mrs(2'b10, 12'h4A2);                    // reserved while pending clear
    chk("R4", {mode_cfg, dll_rst_pend, mode_rsvd}, {7'h22, 2'b01});

    rd(12'h030, 1'b0, "");
    repeat (2) @(negedge clk);
    rd(12'h040, 1'b0, "R10");
    repeat (10) @(negedge clk);
    chk("R10", qh.size(), 0);

    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule